// File: doc/BRIEF.md
# Interrupt Claim and Completion Unit

This block keeps the pending state of up to 127 level-sensitive interrupt sources and carries out the claim and completion handshake for a handler. Each source has its own small gateway state machine. The gateway latches a request into a pending bit. It moves the source into service when the source is claimed. It returns the source to idle when a completion arrives. Source position 0 does not exist, and its pending bit always reads as zero.

Software reaches the block through a single-cycle register bus. Read data is combinational in the access cycle, and state changes at the closing clock edge. Word addresses 0 to 3 return the pending bits, 32 sources per word, with source n at word n/32, bit n%32. Word address 4 is the claim/complete register. A read of it returns the ID offered by a neighbouring ranking block (`arb_id_i`) and clears that pending bit. A write of an ID to it completes service of that source. The ranking block sees the pending vector on `pend_o`. Priorities and thresholds are kept outside this block, so a claim does not depend on any threshold.

Gateway states: `GW_IDLE` (no request held), `GW_PEND` (request latched), `GW_SERVICE` (claimed, requests ignored). Transitions: `GW_IDLE -> GW_PEND` when the request input is high at a clock edge. `GW_PEND -> GW_SERVICE` on a claim of that source. `GW_SERVICE -> GW_IDLE` on a valid completion write of that source. All other cases hold the state.

Top module: `intc_claim_unit`

## Requirements
- R1: After reset, all four pending words read 0 and a claim read returns 0.
- R2: A source whose request input is high at a clock edge has its pending bit set after that edge, at word n/32 and bit n%32. The bit stays set when the request drops.
- R3: Bit 0 of pending word 0 always reads 0, even when request input 0 is high.
- R4: A read of word address 4 returns `arb_id_i`, zero-extended, when that source is pending. It returns 0 when `arb_id_i` is 0 or names a source that is not pending.
- R5: A claim read that returns a nonzero ID clears that pending bit at the clock edge that ends the read.
- R6: While a source is in service, its request input has no effect, and its pending bit stays 0.
- R7: A write of the claimed ID to word address 4 ends service at that edge. If the request is still high, the pending bit is set again at the following edge.
- R8: A completion write is ignored when its data is 0, when its data has any bit at or above bit 7 set, or when it names a source that is not in service.
- R9: When a claim of a source and a new request from that same source fall in the same cycle, the clear takes effect and the pending bit reads 0 afterwards.
- R10: Reads of word addresses 5 to 7 return 0, and writes to word addresses 0 to 3 leave the pending bits unchanged.
- R11: `pend_o` carries the same pending bits that the bus reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req_i | input | 128 | Level request per source; bit 0 unused |
| arb_id_i | input | 7 | Best pending ID from the ranking block |
| pend_o | output | 128 | Pending vector to the ranking block |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |

## Verification
A gateway that is stuck or entered the wrong state shows up on the very next bus read. A source stuck in `GW_SERVICE` keeps its pending bit at 0 while its request is high. A missed claim leaves the bit set one cycle after the claim read. A wrongly accepted completion brings the bit back one cycle after the bad write. Because reads are combinational, every check of pending state costs only one bus cycle after the edge that should have changed it.

// File: rtl/intc_claim_pkg.sv
package intc_claim_pkg;
    localparam int BUS_DW = 32;

    typedef enum logic [1:0] {
        GW_IDLE    = 2'd0,
        GW_PEND    = 2'd1,
        GW_SERVICE = 2'd2
    } gw_state_e;
endpackage

// File: rtl/intc_src_gate.sv
module intc_src_gate
    import intc_claim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic claim_i,
    input  logic cpl_i,
    output logic pend_o,
    output logic busy_o
);
    gw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE:    if (req_i)   state_d = GW_PEND;
            GW_PEND:    if (claim_i) state_d = GW_SERVICE;
            GW_SERVICE: if (cpl_i)   state_d = GW_IDLE;
            default:                 state_d = GW_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == GW_PEND);
        busy_o = (state_q == GW_SERVICE);
    end

    a_r2_pend_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GW_PEND && !claim_i) |=> pend_o);
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GW_PEND && claim_i) |=> (!pend_o && busy_o));
    a_r6_service_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !cpl_i) |=> (busy_o && !pend_o));
    a_r7_complete_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cpl_i) |=> (!busy_o && !pend_o));
endmodule

// File: rtl/intc_claim_regs.sv
module intc_claim_regs
    import intc_claim_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int ID_W    = $clog2(NUM_SRC),
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [BUS_DW-1:0]  bus_wdata_i,
    output logic [BUS_DW-1:0]  bus_rdata_o,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] busy_i,
    input  logic [ID_W-1:0]    arb_id_i,
    output logic [NUM_SRC-1:0] claim_vec_o,
    output logic [NUM_SRC-1:0] cpl_vec_o
);
    localparam int NUM_WORDS = NUM_SRC / BUS_DW;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [ADDR_W-1:0] CLAIM_ADDR = ADDR_W'(NUM_WORDS);

    logic [BUS_DW-1:0] words [NUM_WORDS];
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_words
        assign words[w] = pend_i[w*BUS_DW +: BUS_DW];
    end

    logic              claim_rd, cpl_wr, cpl_ok, word_rd;
    logic [ID_W-1:0]   claim_id, wr_id;
    logic              wr_high_zero;

    always_comb begin
        claim_rd     = bus_sel_i && !bus_we_i && (bus_addr_i == CLAIM_ADDR);
        cpl_wr       = bus_sel_i &&  bus_we_i && (bus_addr_i == CLAIM_ADDR);
        word_rd      = bus_sel_i && !bus_we_i && (bus_addr_i < CLAIM_ADDR);
        claim_id     = pend_i[arb_id_i] ? arb_id_i : '0;
        wr_id        = bus_wdata_i[ID_W-1:0];
        wr_high_zero = (bus_wdata_i[BUS_DW-1:ID_W] == '0);
        cpl_ok       = cpl_wr && wr_high_zero && (wr_id != '0) && busy_i[wr_id];
    end

    always_comb begin
        claim_vec_o = '0;
        cpl_vec_o   = '0;
        if (claim_rd && claim_id != '0) claim_vec_o = NUM_SRC'(1) << claim_id;
        if (cpl_ok)                     cpl_vec_o   = NUM_SRC'(1) << wr_id;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (claim_rd)     bus_rdata_o = BUS_DW'(claim_id);
        else if (word_rd) bus_rdata_o = words[bus_addr_i[WIDX_W-1:0]];
    end

    a_r4_claim_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && !pend_i[arb_id_i]) |-> (bus_rdata_o == '0 && claim_vec_o == '0));
    a_r8_bad_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_wr && (!wr_high_zero || !busy_i[wr_id])) |-> (cpl_vec_o == '0));
    a_r3_no_claim_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !claim_vec_o[0] && !cpl_vec_o[0]);
    a_r5_claim_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec_o) && $onehot0(cpl_vec_o));
endmodule

// File: rtl/intc_claim_unit.sv
module intc_claim_unit
    import intc_claim_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int ID_W    = $clog2(NUM_SRC),
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req_i,
    input  logic [ID_W-1:0]    arb_id_i,
    output logic [NUM_SRC-1:0] pend_o,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [BUS_DW-1:0]  bus_wdata_i,
    output logic [BUS_DW-1:0]  bus_rdata_o
);
    logic [NUM_SRC-1:0] pend, busy, claim_vec, cpl_vec;

    assign pend[0] = 1'b0;
    assign busy[0] = 1'b0;

    for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
        intc_src_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (src_req_i[i]),
            .claim_i (claim_vec[i]),
            .cpl_i   (cpl_vec[i]),
            .pend_o  (pend[i]),
            .busy_o  (busy[i])
        );
    end

    intc_claim_regs #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (bus_sel_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .pend_i      (pend),
        .busy_i      (busy),
        .arb_id_i    (arb_id_i),
        .claim_vec_o (claim_vec),
        .cpl_vec_o   (cpl_vec)
    );

    assign pend_o = pend;

    // R6: nothing can be pending and in service at once
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & busy) == '0);
endmodule

// File: tb/intc_claim_unit_tb_top.sv
module intc_claim_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src_req = '0;
    logic [6:0]   arb_id = '0;
    logic [127:0] pend;
    logic         sel = 1'b0, we = 1'b0;
    logic [2:0]   addr = '0;
    logic [31:0]  wdata = '0, rdata;

    int checks = 0, errors = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    intc_claim_unit dut_i (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .arb_id_i(arb_id),
        .pend_o(pend), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata)
    );

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    // monitor: compares read data against the scoreboard
    always begin
        @(negedge clk);
        #1;
        if (sel && !we) begin
            if (exp_q.size() == 0) begin
                errors++; checks++;
                $display("FAIL unexpected read: actual %h expected none", rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                checks++;
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic chk_pend(input logic [127:0] e, input string t);
        #1;
        checks++;
        if (pend !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, pend, e);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int w = 0; w < 4; w++) rd(3'(w), 32'h0, "R1 reset word");
        rd(3'd4, 32'h0, "R1 reset claim");
        // raise sources 0, 5, 40, 127
        @(negedge clk);
        sel = 1'b0;
        src_req[0] = 1'b1; src_req[5] = 1'b1; src_req[40] = 1'b1; src_req[127] = 1'b1;
        idle();
        rd(3'd0, 32'h0000_0020, "R3 bit0 zero / R2 src5");
        rd(3'd1, 32'h0000_0100, "R2 src40");
        rd(3'd3, 32'h8000_0000, "R2 src127");
        idle();
        chk_pend((128'd1 << 5) | (128'd1 << 40) | (128'd1 << 127), "R11 pend_o");
        src_req[5] = 1'b0;
        idle();
        rd(3'd0, 32'h0000_0020, "R2 latched after drop");
        // claim 5
        arb_id = 7'd5;
        rd(3'd4, 32'd5, "R4 claim src5");
        rd(3'd0, 32'h0, "R5 cleared after claim");
        src_req[5] = 1'b1;
        idle(); idle();
        rd(3'd0, 32'h0, "R6 request ignored in service");
        rd(3'd4, 32'h0, "R4 claim of non-pending id");
        arb_id = 7'd0;
        rd(3'd4, 32'h0, "R4 claim with id 0");
        // bad completions
        wr(3'd4, 32'd0);
        wr(3'd4, 32'h85);
        wr(3'd4, 32'd40);
        idle(); idle();
        rd(3'd0, 32'h0, "R8 src5 still in service");
        rd(3'd1, 32'h0000_0100, "R8 src40 unaffected");
        // good completion with request still high
        wr(3'd4, 32'd5);
        rd(3'd0, 32'h0, "R7 idle right after complete");
        rd(3'd0, 32'h0000_0020, "R7 re-pend one edge later");
        // same-cycle claim and request on 40
        arb_id = 7'd40;
        rd(3'd4, 32'd40, "R9 claim src40 with request high");
        idle();
        rd(3'd1, 32'h0, "R9 clear wins");
        src_req[40] = 1'b0;
        wr(3'd4, 32'd40);
        idle(); idle();
        rd(3'd1, 32'h0, "R7 no re-pend when request low");
        // unmapped and read-only addresses
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0);
        rd(3'd0, 32'h0000_0020, "R10 pending word not writable");
        rd(3'd3, 32'h8000_0000, "R10 word3 unchanged");
        rd(3'd5, 32'h0, "R10 addr5 reads 0");
        rd(3'd7, 32'h0, "R10 addr7 reads 0");
        arb_id = 7'd127;
        rd(3'd4, 32'd127, "R4 claim src127");
        rd(3'd3, 32'h0, "R5 src127 cleared");
        idle(); idle();
        chk_pend(128'd1 << 5, "R11 pend_o final");
        if (exp_q.size() != 0) begin
            errors++; checks++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule